// File: doc/BRIEF.md
# Sector Erase Acceptance Window Controller

This block sits between the command decoder of a flash array and its erase engine. A first sector erase command opens an acceptance window, and the block records the addressed sector in a selection bitmap. While the window is open, further sector erase commands add their sectors to the bitmap. Each one restarts the full timeout, which is counted in microsecond ticks. When the timeout runs out with no new sector command, the block raises a one-cycle erase-start pulse and holds busy high until the erase engine reports completion. The status bit seen by software reads 0 while sectors can still be added and 1 once erasure has begun.

A chip erase from idle skips the window and starts at once with every sector selected. While the window is open, any command other than a sector erase or an erase-suspend abandons the window. Once the erase runs, every command except erase-suspend is ignored. A suspended erase can be picked up again by a later command. The erase engine can also report completion while suspended.

Top module: `erase_window_ctrl`

## Requirements
- R1: After reset the sector bitmap is all zero, erase_start, erase_busy and dq3_status are low, and win_state is idle (code 0).
- R2: A sector erase command in idle leads, one cycle later, to win_state open (code 1) and a bitmap with only the addressed bit set (bit n for index n). dq3_status stays 0.
- R3: While open, the clock cycle that carries the TIMEOUT_US-th us_tick since the last sector command causes erase_start to be high for exactly the following cycle. In that same cycle erase_busy and dq3_status go high and win_state becomes erasing (code 2).
- R4: A sector erase command while open ORs its bit into the bitmap and restarts the count from zero. It wins over an us_tick in the same cycle.
- R5: An erase-suspend command while open is ignored. The state, the bitmap and the running count are all unchanged.
- R6: A chip erase or other command while open returns the block to idle with a cleared bitmap, and no erase-start follows.
- R7: A chip erase in idle produces erase_start one cycle later, with every bitmap bit set and win_state erasing.
- R8: While erasing, sector erase, chip erase and other commands are ignored. The bitmap and the state are held.
- R9: An erase-suspend while erasing moves win_state to suspended (code 3) with busy, dq3_status and the bitmap held. An other command while suspended returns the block to erasing.
- R10: erase_done while erasing or suspended takes priority over any command. One cycle later the state is idle, the bitmap is zero, and busy and dq3_status are low.
- R11: In idle, erase-suspend, other commands, erase_done and us_tick have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sector_erase | input | 1 | Decoded sector erase command, one cycle |
| cmd_sector_idx | input | IDX_W | Sector index for the sector erase command |
| cmd_chip_erase | input | 1 | Decoded chip erase command |
| cmd_erase_suspend | input | 1 | Decoded erase-suspend command |
| cmd_other | input | 1 | Any other decoded command |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| erase_done | input | 1 | Erase engine reports completion |
| sector_sel | output | NUM_SECTORS | Sectors selected for erasure |
| erase_start | output | 1 | One-cycle pulse when the erase begins |
| erase_busy | output | 1 | Erase running or suspended |
| dq3_status | output | 1 | 0 while sectors may be added, 1 once erasure began |
| win_state | output | 2 | 0 idle, 1 open, 2 erasing, 3 suspended |

## Verification
Every result is registered exactly once. A command, tick or done applied in one cycle therefore shows up on sector_sel, win_state, erase_busy, dq3_status and erase_start after the next rising edge. The bench drives each input on the falling edge, holds it through one rising edge, and samples on the following falling edge. Expiry is checked one tick early (still open, no pulse), then on the expiring tick (pulse seen), then one cycle later (pulse gone). A sweep over every pair of first and added sector, with a retrigger in between, computes the expected bitmap as the OR of two one-hot values.

// File: rtl/erase_window_pkg.sv
package erase_window_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_OPEN  = 2'd1,
    WIN_ERASE = 2'd2,
    WIN_HOLD  = 2'd3
  } win_state_e;

  typedef struct packed {
    logic clear;
    logic fill;
    logic load;
    logic add;
  } map_op_t;

endpackage

// File: rtl/erase_window_timer.sv
module erase_window_timer #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic expired
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = run && tick && !restart && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && tick) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/erase_sector_map.sv
module erase_sector_map
  import erase_window_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned IDX_W       = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  map_op_t                op,
  input  logic [IDX_W-1:0]       idx,
  output logic [NUM_SECTORS-1:0] map
);

  logic [NUM_SECTORS-1:0] map_q;
  logic [NUM_SECTORS-1:0] map_d;
  logic [NUM_SECTORS-1:0] hit;
  logic                   map_en;

  genvar g;
  generate
    for (g = 0; g < NUM_SECTORS; g++) begin : g_bit
      assign hit[g] = (idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    map_en = 1'b1;
    map_d  = map_q;
    if (op.clear) begin
      map_d = '0;
    end else if (op.fill) begin
      map_d = '1;
    end else if (op.load) begin
      map_d = hit;
    end else if (op.add) begin
      map_d = map_q | hit;
    end else begin
      map_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end

  assign map = map_q;

endmodule

// File: rtl/erase_window_fsm.sv
module erase_window_fsm
  import erase_window_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_sector,
  input  logic       cmd_chip,
  input  logic       cmd_suspend,
  input  logic       cmd_other,
  input  logic       done,
  input  logic       expired,
  output map_op_t    map_op,
  output logic       tmr_restart,
  output logic       tmr_run,
  output logic       start,
  output logic       busy,
  output win_state_e state
);

  win_state_e state_q;
  win_state_e state_d;
  logic       start_q;
  logic       start_d;

  always_comb begin
    state_d     = state_q;
    start_d     = 1'b0;
    map_op      = '0;
    tmr_restart = 1'b0;
    tmr_run     = (state_q == WIN_OPEN);
    unique case (state_q)
      WIN_IDLE: begin
        if (cmd_sector) begin
          state_d     = WIN_OPEN;
          map_op.load = 1'b1;
          tmr_restart = 1'b1;
        end else if (cmd_chip) begin
          state_d     = WIN_ERASE;
          map_op.fill = 1'b1;
          start_d     = 1'b1;
        end
      end
      WIN_OPEN: begin
        if (cmd_sector) begin
          map_op.add  = 1'b1;
          tmr_restart = 1'b1;
        end else if (cmd_chip || cmd_other) begin
          state_d      = WIN_IDLE;
          map_op.clear = 1'b1;
        end else if (expired) begin
          state_d = WIN_ERASE;
          start_d = 1'b1;
        end
      end
      WIN_ERASE: begin
        if (done) begin
          state_d      = WIN_IDLE;
          map_op.clear = 1'b1;
        end else if (cmd_suspend) begin
          state_d = WIN_HOLD;
        end
      end
      WIN_HOLD: begin
        if (done) begin
          state_d      = WIN_IDLE;
          map_op.clear = 1'b1;
        end else if (cmd_other) begin
          state_d = WIN_ERASE;
        end
      end
      default: begin
        state_d      = WIN_IDLE;
        map_op.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign state = state_q;
  assign start = start_q;
  assign busy  = (state_q == WIN_ERASE) || (state_q == WIN_HOLD);

endmodule

// File: rtl/erase_window_ctrl.sv
module erase_window_ctrl
  import erase_window_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned TIMEOUT_US  = 50,
  parameter int unsigned IDX_W       = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_sector_erase,
  input  logic [IDX_W-1:0]       cmd_sector_idx,
  input  logic                   cmd_chip_erase,
  input  logic                   cmd_erase_suspend,
  input  logic                   cmd_other,
  input  logic                   us_tick,
  input  logic                   erase_done,
  output logic [NUM_SECTORS-1:0] sector_sel,
  output logic                   erase_start,
  output logic                   erase_busy,
  output logic                   dq3_status,
  output logic [1:0]             win_state
);

  map_op_t    map_op;
  logic       tmr_restart;
  logic       tmr_run;
  logic       tmr_expired;
  win_state_e fsm_state;

  erase_window_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_sector  (cmd_sector_erase),
    .cmd_chip    (cmd_chip_erase),
    .cmd_suspend (cmd_erase_suspend),
    .cmd_other   (cmd_other),
    .done        (erase_done),
    .expired     (tmr_expired),
    .map_op      (map_op),
    .tmr_restart (tmr_restart),
    .tmr_run     (tmr_run),
    .start       (erase_start),
    .busy        (erase_busy),
    .state       (fsm_state)
  );

  erase_window_timer #(
    .LIMIT (TIMEOUT_US)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .tick    (us_tick),
    .expired (tmr_expired)
  );

  erase_sector_map #(
    .NUM_SECTORS (NUM_SECTORS),
    .IDX_W       (IDX_W)
  ) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (map_op),
    .idx   (cmd_sector_idx),
    .map   (sector_sel)
  );

  assign dq3_status = erase_busy;
  assign win_state  = fsm_state;

endmodule

// File: rtl/erase_window_chk.sv
module erase_window_chk #(
  parameter int unsigned NUM_SECTORS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_sector_erase,
  input logic                   cmd_erase_suspend,
  input logic                   erase_done,
  input logic [NUM_SECTORS-1:0] sector_sel,
  input logic                   erase_start,
  input logic                   erase_busy,
  input logic                   dq3_status,
  input logic [1:0]             win_state
);

  // R3
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R3
  busy_rise_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> (erase_start && dq3_status));

  // R2
  open_dq3_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_state == 2'd1) |-> (!dq3_status && !erase_busy));

  // R1
  idle_map_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_state == 2'd0) |-> (sector_sel == '0));

  // R8
  busy_map_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !erase_done) |=> $stable(sector_sel));

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && erase_done) |=> (!erase_busy && (sector_sel == '0) && (win_state == 2'd0)));

  // R5
  suspend_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_state == 2'd1) && cmd_erase_suspend && !cmd_sector_erase) |=> $stable(sector_sel));

endmodule

bind erase_window_ctrl erase_window_chk #(
  .NUM_SECTORS (NUM_SECTORS)
) chk_i (
  .clk               (clk),
  .rst_n             (rst_n),
  .cmd_sector_erase  (cmd_sector_erase),
  .cmd_erase_suspend (cmd_erase_suspend),
  .erase_done        (erase_done),
  .sector_sel        (sector_sel),
  .erase_start       (erase_start),
  .erase_busy        (erase_busy),
  .dq3_status        (dq3_status),
  .win_state         (win_state)
);

// File: tb/erase_window_ctrl_tb_top.sv
`timescale 1ns/1ps
module erase_window_ctrl_tb_top;

  localparam int unsigned NS  = 8;
  localparam int unsigned TO  = 4;
  localparam int unsigned IW  = 3;

  logic          clk;
  logic          rst_n;
  logic          cmd_sector_erase;
  logic [IW-1:0] cmd_sector_idx;
  logic          cmd_chip_erase;
  logic          cmd_erase_suspend;
  logic          cmd_other;
  logic          us_tick;
  logic          erase_done;
  logic [NS-1:0] sector_sel;
  logic          erase_start;
  logic          erase_busy;
  logic          dq3_status;
  logic [1:0]    win_state;

  int checks;
  int fails;
  bit finished;

  erase_window_ctrl #(
    .NUM_SECTORS (NS),
    .TIMEOUT_US  (TO),
    .IDX_W       (IW)
  ) dut_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd_sector_erase  (cmd_sector_erase),
    .cmd_sector_idx    (cmd_sector_idx),
    .cmd_chip_erase    (cmd_chip_erase),
    .cmd_erase_suspend (cmd_erase_suspend),
    .cmd_other         (cmd_other),
    .us_tick           (us_tick),
    .erase_done        (erase_done),
    .sector_sel        (sector_sel),
    .erase_start       (erase_start),
    .erase_busy        (erase_busy),
    .dq3_status        (dq3_status),
    .win_state         (win_state)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmd_sector_erase  = 1'b0;
    cmd_chip_erase    = 1'b0;
    cmd_erase_suspend = 1'b0;
    cmd_other         = 1'b0;
    us_tick           = 1'b0;
    erase_done        = 1'b0;
  endtask

  task automatic sector(input int idx);
    cmd_sector_erase = 1'b1;
    cmd_sector_idx   = IW'(idx);
    step();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      us_tick = 1'b1;
      step();
    end
  endtask

  task automatic expect_out(input string req, input logic [NS-1:0] sel,
                            input logic st, input logic bz, input logic [1:0] ws);
    check(req, "sector_sel", 32'(sector_sel), 32'(sel));
    check(req, "erase_start", 32'(erase_start), 32'(st));
    check(req, "erase_busy", 32'(erase_busy), 32'(bz));
    check(req, "dq3_status", 32'(dq3_status), 32'(bz));
    check(req, "win_state", 32'(win_state), 32'(ws));
  endtask

  task automatic finish_erase();
    erase_done = 1'b1;
    step();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    cmd_sector_erase = 1'b0;
    cmd_sector_idx = '0;
    cmd_chip_erase = 1'b0;
    cmd_erase_suspend = 1'b0;
    cmd_other = 1'b0;
    us_tick = 1'b0;
    erase_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_out("R1", '0, 1'b0, 1'b0, 2'd0);
    rst_n = 1'b1;
    step();
    expect_out("R1", '0, 1'b0, 1'b0, 2'd0);

    // R11 idle ignores suspend, other, done and ticks
    cmd_erase_suspend = 1'b1; step();
    cmd_other = 1'b1; step();
    erase_done = 1'b1; step();
    ticks(TO + 1);
    expect_out("R11", '0, 1'b0, 1'b0, 2'd0);

    // R2 first sector opens window
    sector(5);
    expect_out("R2", NS'(1) << 5, 1'b0, 1'b0, 2'd1);
    // R3 expiry timing
    ticks(TO - 1);
    expect_out("R3", NS'(1) << 5, 1'b0, 1'b0, 2'd1);
    ticks(1);
    expect_out("R3", NS'(1) << 5, 1'b1, 1'b1, 2'd2);
    step();
    expect_out("R3", NS'(1) << 5, 1'b0, 1'b1, 2'd2);

    // R8 commands ignored while erasing
    sector(1); cmd_chip_erase = 1'b1; step(); cmd_other = 1'b1; step(); ticks(TO);
    expect_out("R8", NS'(1) << 5, 1'b0, 1'b1, 2'd2);

    // R9 suspend then resume by other command
    cmd_erase_suspend = 1'b1; step();
    expect_out("R9", NS'(1) << 5, 1'b0, 1'b1, 2'd3);
    sector(2); cmd_erase_suspend = 1'b1; step();
    expect_out("R9", NS'(1) << 5, 1'b0, 1'b1, 2'd3);
    cmd_other = 1'b1; step();
    expect_out("R9", NS'(1) << 5, 1'b0, 1'b1, 2'd2);

    // R10 done wins over simultaneous suspend
    erase_done = 1'b1; cmd_erase_suspend = 1'b1; step();
    expect_out("R10", '0, 1'b0, 1'b0, 2'd0);
    // R10 done while suspended
    cmd_chip_erase = 1'b1; step();
    cmd_erase_suspend = 1'b1; step();
    finish_erase();
    expect_out("R10", '0, 1'b0, 1'b0, 2'd0);

    // R7 chip erase from idle
    cmd_chip_erase = 1'b1; step();
    expect_out("R7", '1, 1'b1, 1'b1, 2'd2);
    finish_erase();

    // R6 abort by other command, then no start
    sector(3); ticks(2);
    cmd_other = 1'b1; step();
    expect_out("R6", '0, 1'b0, 1'b0, 2'd0);
    ticks(TO);
    expect_out("R6", '0, 1'b0, 1'b0, 2'd0);
    // R6 abort by chip erase
    sector(4);
    cmd_chip_erase = 1'b1; step();
    expect_out("R6", '0, 1'b0, 1'b0, 2'd0);

    // R5 suspend in window ignored, count keeps running
    sector(6); ticks(2);
    cmd_erase_suspend = 1'b1; us_tick = 1'b1; step();
    expect_out("R5", NS'(1) << 6, 1'b0, 1'b0, 2'd1);
    ticks(TO - 3);
    expect_out("R5", NS'(1) << 6, 1'b1, 1'b1, 2'd2);
    finish_erase();

    // R4 sector command wins over simultaneous tick and restarts count
    sector(0); ticks(TO - 1);
    cmd_sector_erase = 1'b1; cmd_sector_idx = 3'd7; us_tick = 1'b1; step();
    expect_out("R4", 8'h81, 1'b0, 1'b0, 2'd1);
    ticks(TO - 1);
    expect_out("R4", 8'h81, 1'b0, 1'b0, 2'd1);
    ticks(1);
    expect_out("R4", 8'h81, 1'b1, 1'b1, 2'd2);
    finish_erase();

    // R4 sweep of every first/added sector pair with retrigger
    for (int i = 0; i < NS; i++) begin
      for (int j = 0; j < NS; j++) begin
        logic [NS-1:0] exp_map;
        exp_map = (NS'(1) << i) | (NS'(1) << j);
        sector(i);
        ticks(TO - 1);
        sector(j);
        ticks(TO - 1);
        check("R4", "sweep open", 32'(win_state), 32'd1);
        ticks(1);
        check("R4", "sweep map", 32'(sector_sel), 32'(exp_map));
        check("R3", "sweep start", 32'(erase_start), 32'd1);
        finish_erase();
        check("R10", "sweep idle", 32'(sector_sel), 32'd0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule